// File: doc/BRIEF.md
# Comma Alignment Slip Controller

This block brings an oversampled serial receiver onto 8b10b character boundaries. On a start request it works through a numbered series of slip attempts. In each attempt it sends a pair of single-cycle bitslip pulses to the deserializer, because the deserializer samples at twice the bit rate. It then lets the data settle, pulses a reset into the comma detector and waits for a lock window before it samples the comma-found flag. If the flag is set, alignment ends and the receiver is declared ready. If it is clear, the controller moves on to the next attempt.

The second half of each pass raises a word-slip control. Two shared decoders each serve a lane pair and take one lane per system clock. The word-slip control swaps which clock parity each lane of the pair uses, which extends the reach of the slip to two clock cycles. The controller brings out the decoder lane-pair select that results from this, so the decode path can steer its muxes. When every attempt in a pass fails, the controller waits out a long back-off and then begins a new pass. All waits are cycle counts derived from the clock frequency, and they can be overridden.

Top module: `comma_slip_ctrl`

## Requirements
- R1: After reset, bitslip_o, wordslip_o, comma_rst_o and rx_ready_o are low, and they stay low until start_i is seen high.
- R2: Each attempt issues exactly two bitslip_o pulses before its comma reset. Each pulse is one cycle wide, and the two pulses are separated by exactly one idle cycle.
- R3: Attempts are numbered 1 to MAX_ATTEMPTS (default 10). wordslip_o is 1 during attempts numbered above WS_AFTER (default 5) and 0 otherwise. It takes its value before the attempt's first bitslip pulse and holds it through that attempt.
- R4: comma_rst_o is a one-cycle pulse, raised exactly SLIP_WAIT_CYC+1 cycles after the attempt's second bitslip pulse.
- R5: comma_i is sampled LOCK_WAIT_CYC cycles after the comma_rst_o pulse. If it is 1, rx_ready_o rises on the next cycle (LOCK_WAIT_CYC+1 after the pulse) and no further slips are issued.
- R6: After a failed attempt other than the last, the next attempt's first bitslip pulse comes LOCK_WAIT_CYC+2 cycles after the failed attempt's comma_rst_o pulse.
- R7: After the last attempt fails, a new pass starts at attempt 1 (wordslip_o 0). Its first bitslip pulse comes LOCK_WAIT_CYC+BACKOFF_CYC+2 cycles after the last comma_rst_o pulse.
- R8: rx_ready_o is never high while an alignment pass is in progress. A start_i while ready drops rx_ready_o on the next cycle and begins a new pass at attempt 1.
- R9: pair_sel_o = 0 means the decoders serve lanes 0 and 2, and 1 means lanes 1 and 3. It alternates every cycle while wordslip_o is unchanged, and it repeats its previous value in the cycle where wordslip_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin an alignment pass |
| comma_i | input | 1 | Comma detector reports a locked character boundary |
| bitslip_o | output | 1 | Single-cycle slip pulse to the deserializer |
| wordslip_o | output | 1 | Swaps the decode parity of the shared decoders |
| comma_rst_o | output | 1 | Single-cycle reset pulse to the comma detector |
| rx_ready_o | output | 1 | Alignment achieved; receive path may be used |
| pair_sel_o | output | 1 | Lane pair the shared decoders handle this cycle |

## Verification
The properties assume that comma_i stays steady from a comma reset pulse until the end of the lock window, so the sampled value is the detector's verdict. They also assume that start_i is a synchronous one-cycle request. The stimulus meets both assumptions. The comma flag is a model that changes only on the falling edge in the cycle of a comma reset pulse: it goes high once a chosen number of pulses has been counted and stays there until the next pass is armed. The start request is driven well clear of the active edge for exactly one clock.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_WS      = 4'd1,
    ST_SLIP_A  = 4'd2,
    ST_GAP     = 4'd3,
    ST_SLIP_B  = 4'd4,
    ST_SETTLE  = 4'd5,
    ST_CRST    = 4'd6,
    ST_LOCKW   = 4'd7,
    ST_BACKOFF = 4'd8,
    ST_READY   = 4'd9
  } ccs_state_e;

endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ccs_wait_timer.sv
module ccs_wait_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/ccs_phase_gen.sv
module ccs_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wordslip_i,
  output logic pair_sel_o
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // Odd cycles (phase 1) serve lanes 0/2 unless the word slip swaps parity.
  assign pair_sel_o = ~(phase_q ^ wordslip_i);

endmodule

// File: rtl/ccs_slip_fsm.sv
module ccs_slip_fsm
  import ccs_pkg::*;
#(
  parameter int unsigned MAX_ATTEMPTS  = 10,
  parameter int unsigned WS_AFTER      = 5,
  parameter int unsigned SLIP_WAIT_CYC = 125,
  parameter int unsigned LOCK_WAIT_CYC = 12500,
  parameter int unsigned BACKOFF_CYC   = 125000000,
  parameter int unsigned TW            = 27,
  parameter int unsigned AW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          comma_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          bitslip_o,
  output logic          wordslip_o,
  output logic          comma_rst_o,
  output logic          rx_ready_o
);

  localparam logic [AW-1:0] ATT_FIRST = AW'(1);
  localparam logic [AW-1:0] ATT_LAST  = AW'(MAX_ATTEMPTS);
  localparam logic [AW-1:0] ATT_WS    = AW'(WS_AFTER);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SLIP_WAIT_CYC - 1);
  localparam logic [TW-1:0] LOCK_LD   = TW'(LOCK_WAIT_CYC - 1);
  localparam logic [TW-1:0] BACK_LD   = TW'(BACKOFF_CYC - 1);

  ccs_state_e     state_q, state_d;
  logic [AW-1:0]  att_q, att_d;
  logic           ws_q, ws_d;
  logic           att_en;

  always_comb begin
    state_d    = state_q;
    att_d      = att_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WS;
          att_d   = ATT_FIRST;
        end
      end
      ST_WS:     state_d = ST_SLIP_A;
      ST_SLIP_A: state_d = ST_GAP;
      ST_GAP:    state_d = ST_SLIP_B;
      ST_SLIP_B: begin
        state_d    = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = SETTLE_LD;
      end
      ST_SETTLE: begin
        if (tmr_done_i) state_d = ST_CRST;
      end
      ST_CRST: begin
        state_d    = ST_LOCKW;
        tmr_load_o = 1'b1;
        tmr_val_o  = LOCK_LD;
      end
      ST_LOCKW: begin
        if (tmr_done_i) begin
          if (comma_i) begin
            state_d = ST_READY;
          end else if (att_q == ATT_LAST) begin
            state_d    = ST_BACKOFF;
            tmr_load_o = 1'b1;
            tmr_val_o  = BACK_LD;
          end else begin
            state_d = ST_WS;
            att_d   = att_q + AW'(1);
          end
        end
      end
      ST_BACKOFF: begin
        if (tmr_done_i) begin
          state_d = ST_WS;
          att_d   = ATT_FIRST;
        end
      end
      ST_READY: begin
        if (start_i) begin
          state_d = ST_WS;
          att_d   = ATT_FIRST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    att_en = (att_d != att_q);
    ws_d   = (att_d > ATT_WS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= '0;
      ws_q  <= 1'b0;
    end else if (att_en) begin
      att_q <= att_d;
      ws_q  <= ws_d;
    end
  end

  assign bitslip_o   = (state_q == ST_SLIP_A) || (state_q == ST_SLIP_B);
  assign comma_rst_o = (state_q == ST_CRST);
  assign rx_ready_o  = (state_q == ST_READY);
  assign wordslip_o  = ws_q;

endmodule

// File: rtl/comma_slip_ctrl.sv
module comma_slip_ctrl #(
  parameter int unsigned CLK_HZ        = 125000000,
  parameter int unsigned MAX_ATTEMPTS  = 10,
  parameter int unsigned WS_AFTER      = 5,
  parameter int unsigned SLIP_WAIT_CYC = CLK_HZ / 1000000,
  parameter int unsigned LOCK_WAIT_CYC = CLK_HZ / 10000,
  parameter int unsigned BACKOFF_CYC   = CLK_HZ,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic comma_i,
  output logic bitslip_o,
  output logic wordslip_o,
  output logic comma_rst_o,
  output logic rx_ready_o,
  output logic pair_sel_o
);

  localparam int unsigned MAX_SL  = (SLIP_WAIT_CYC > LOCK_WAIT_CYC) ? SLIP_WAIT_CYC : LOCK_WAIT_CYC;
  localparam int unsigned TMR_MAX = (MAX_SL > BACKOFF_CYC) ? MAX_SL : BACKOFF_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned ATT_W   = $clog2(MAX_ATTEMPTS + 1);

  logic             rst_sync_n;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;

  ccs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ccs_wait_timer #(.TW(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  ccs_slip_fsm #(
    .MAX_ATTEMPTS  (MAX_ATTEMPTS),
    .WS_AFTER      (WS_AFTER),
    .SLIP_WAIT_CYC (SLIP_WAIT_CYC),
    .LOCK_WAIT_CYC (LOCK_WAIT_CYC),
    .BACKOFF_CYC   (BACKOFF_CYC),
    .TW            (TMR_W),
    .AW            (ATT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .comma_i     (comma_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .bitslip_o   (bitslip_o),
    .wordslip_o  (wordslip_o),
    .comma_rst_o (comma_rst_o),
    .rx_ready_o  (rx_ready_o)
  );

  ccs_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wordslip_i (wordslip_o),
    .pair_sel_o (pair_sel_o)
  );

endmodule

// File: rtl/comma_slip_ctrl_chk.sv
module comma_slip_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic comma_i,
  input logic bitslip_o,
  input logic wordslip_o,
  input logic comma_rst_o,
  input logic rx_ready_o,
  input logic pair_sel_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  AST_BITSLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bitslip_o |=> !bitslip_o); // R2

  AST_WS_STABLE_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && bitslip_o) |-> $stable(wordslip_o)); // R3

  AST_CRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    comma_rst_o |=> !comma_rst_o); // R4

  AST_READY_AFTER_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(rx_ready_o)) |-> $past(comma_i)); // R5

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_o |-> (!bitslip_o && !comma_rst_o)); // R8

  AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $stable(wordslip_o)) |-> (pair_sel_o != $past(pair_sel_o))); // R9

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$stable(wordslip_o)) |-> $stable(pair_sel_o)); // R9

endmodule

bind comma_slip_ctrl comma_slip_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .comma_i     (comma_i),
  .bitslip_o   (bitslip_o),
  .wordslip_o  (wordslip_o),
  .comma_rst_o (comma_rst_o),
  .rx_ready_o  (rx_ready_o),
  .pair_sel_o  (pair_sel_o)
);

// File: tb/comma_slip_ctrl_bench.sv
module comma_slip_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W_CYC  = 3;
  localparam int L_CYC  = 5;
  localparam int B_CYC  = 40;
  localparam int N_ATT  = 10;
  localparam int WS_LIM = 5;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic comma_i = 1'b0;
  logic bitslip_o, wordslip_o, comma_rst_o, rx_ready_o, pair_sel_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  comma_slip_ctrl #(
    .CLK_HZ        (1000),
    .MAX_ATTEMPTS  (N_ATT),
    .WS_AFTER      (WS_LIM),
    .SLIP_WAIT_CYC (W_CYC),
    .LOCK_WAIT_CYC (L_CYC),
    .BACKOFF_CYC   (B_CYC),
    .SYNC_STAGES   (2)
  ) u_comma_slip_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .comma_i     (comma_i),
    .bitslip_o   (bitslip_o),
    .wordslip_o  (wordslip_o),
    .comma_rst_o (comma_rst_o),
    .rx_ready_o  (rx_ready_o),
    .pair_sel_o  (pair_sel_o)
  );

  typedef struct packed {
    int att;
    bit ws;
    bit bo;
  } exp_t;

  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int total_crst = 0;
  int target_abs = 32'h7fffffff;
  bit mon_en = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected attempts as the design produces them
  bit   pv = 1'b0;
  logic prev_pair, prev_ws, prev_bs, prev_rdy;
  int   bs_cnt = 0;
  int   s1 = 0;
  int   last_crst = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_en) begin
      if (pv) begin
        if (wordslip_o == prev_ws)
          check(pair_sel_o != prev_pair, "R9", "pair_sel toggle", pair_sel_o, !prev_pair);
        else
          check(pair_sel_o == prev_pair, "R9", "pair_sel hold", pair_sel_o, prev_pair);
      end
      if (bitslip_o) begin
        if (prev_bs) check(1'b0, "R2", "bitslip wider than one cycle", 2, 1);
        if (bs_cnt == 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected slip", 1, 0);
          end else begin
            check(wordslip_o == exp_q[0].ws, "R3", "wordslip at first bitslip",
                  wordslip_o, exp_q[0].ws);
            if (exp_q[0].bo)
              check(cyc - last_crst == L_CYC + B_CYC + 2, "R7", "backoff gap",
                    cyc - last_crst, L_CYC + B_CYC + 2);
            else if (exp_q[0].att != 1)
              check(cyc - last_crst == L_CYC + 2, "R6", "retry gap",
                    cyc - last_crst, L_CYC + 2);
          end
          s1 = cyc;
          bs_cnt = 1;
        end else if (bs_cnt == 1) begin
          check(cyc == s1 + 2, "R2", "second bitslip spacing", cyc - s1, 2);
          bs_cnt = 2;
        end else begin
          check(1'b0, "R2", "extra bitslip in attempt", bs_cnt + 1, 2);
        end
      end
      if (comma_rst_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected comma reset", 1, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(bs_cnt == 2, "R2", "bitslips before comma reset", bs_cnt, 2);
          check(cyc == s1 + W_CYC + 3, "R4", "comma reset delay", cyc - s1 - 2, W_CYC + 1);
          check(wordslip_o == it.ws, "R3", "wordslip in attempt", wordslip_o, it.ws);
        end
        bs_cnt = 0;
        last_crst = cyc;
        total_crst = total_crst + 1;
      end
      if (rx_ready_o && !prev_rdy) begin
        check(cyc == last_crst + L_CYC + 1, "R5", "ready delay", cyc - last_crst, L_CYC + 1);
        check(exp_q.size() == 0, "R8", "ready before last attempt", exp_q.size(), 0);
      end
      pv = 1'b1;
      prev_pair = pair_sel_o;
      prev_ws   = wordslip_o;
      prev_bs   = bitslip_o;
      prev_rdy  = rx_ready_o;
    end
    comma_i = (total_crst >= target_abs);
  end

  // Driver: queues the attempts a pass must produce, then starts it
  task automatic run_pass(input int lock_at);
    int last_att;
    last_att = 0;
    for (int n = 1; n <= lock_at; n++) begin
      exp_t it;
      it.att = ((n - 1) % N_ATT) + 1;
      it.ws  = (it.att > WS_LIM);
      it.bo  = (n > N_ATT) && (it.att == 1);
      exp_q.push_back(it);
      last_att = it.att;
    end
    target_abs = total_crst + lock_at;
    @(posedge clk); #2;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    @(negedge clk);
    check(rx_ready_o == 1'b0, "R8", "ready low once pass starts", rx_ready_o, 0);
    for (int k = 0; k < 5000; k++) begin
      if (rx_ready_o) break;
      @(negedge clk);
    end
    check(rx_ready_o == 1'b1, "R5", "ready reached", rx_ready_o, 1);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5", "attempts left over", exp_q.size(), 0);
    check(rx_ready_o == 1'b1, "R5", "ready held", rx_ready_o, 1);
    check(wordslip_o == (last_att > WS_LIM), "R3", "final wordslip",
          wordslip_o, int'(last_att > WS_LIM));
    exp_q.delete();
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rx_ready_o == 1'b0 && bitslip_o == 1'b0, "R1", "outputs in reset", rx_ready_o, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 mon_en = 1'b1;
    repeat (20) @(negedge clk);
    check(bitslip_o == 1'b0, "R1", "idle bitslip", bitslip_o, 0);
    check(wordslip_o == 1'b0, "R1", "idle wordslip", wordslip_o, 0);
    check(comma_rst_o == 1'b0, "R1", "idle comma reset", comma_rst_o, 0);
    check(rx_ready_o == 1'b0, "R1", "idle ready", rx_ready_o, 0);

    run_pass(3);   // early lock, wordslip low
    run_pass(7);   // restart from ready, crosses the wordslip boundary
    run_pass(10);  // lock on the last attempt of a pass
    run_pass(12);  // full failed pass, back-off, lock on second try
    run_pass(1);   // immediate lock

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < WDOG; t++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule